// File: doc/BRIEF.md
# TDM Command and Audio Frame Receiver

This block is the receive side of a serial link where one data line carries both a control word and several audio channels. It is clocked by the link's bit clock and sees a frame clock whose rising edge starts each frame. Every frame is cut into 32-bit packets, sent most significant bit first. The first packet holds a command and the packets after it hold audio channel slots. The block gives the upper 24 bits of the command packet to the host logic. It also gives the upper 24 bits of each audio packet that falls inside a window of slots set by this device's configuration. Each word comes with a one-cycle strobe.

Two frame sizes are supported. The short frame is 256 bit clocks long and carries six audio slots, followed by one packet that is ignored. The long frame is 384 bit clocks long and carries eight audio slots, followed by padding that is ignored. If a frame-clock edge arrives after the wrong number of bits, a framing error flag is raised for the frame that follows.

For multi-device systems, a token passes along a daisy chain so that each device can learn its ID. While ID mode is on, the position of the bit at which the token first reaches this device sets the device's ID. Two bit clocks later the device passes the token on through its chain output.

Top module: `tdm_cmd_audio_rx`

## Requirements
- R1: After reset, cmd_valid_o, aud_valid_o, frame_err_o, id_valid_o and chain_out_o are all 0.
- R2: A rising edge on frame_clk_i, sampled on clk, marks bit 0 of the command packet. No strobe is produced before the first such edge.
- R3: When the last bit (bit position 31) of packet 0 has been sampled, cmd_valid_o is high for exactly the next cycle. During that cycle cmd_data_o holds packet bits [31:8], where bit 31 is the first bit received.
- R4: Packet p (p >= 1) is audio slot p-1. The slot is captured when start_slot_i <= slot < start_slot_i + slot_count_i. On a capture, aud_valid_o pulses high for the single cycle after the packet's last bit. During that pulse aud_data_o holds packet bits [31:8] and aud_slot_o holds the slot number.
- R5: When long_frame_i is 0 (sampled at the frame edge), the frame is 256 bits and only slots 0 to 5 can be captured. When it is 1, the frame is 384 bits and slots 0 to 7 can be captured. Packets past the last slot, and bits past the frame length, produce no strobe.
- R6: At a frame edge after the first one, frame_err_o is set if the number of bits since the previous edge differs from the previous frame's length, and cleared if it matches. The flag holds until the next edge.
- R7: With id_mode_i high, id_valid_o is cleared at each frame edge. The first bit position c < 60 at which chain_in_i is sampled high sets dev_id_o = floor(c/2)+1 and id_valid_o = 1 in the following cycle. A token first seen at position 60 or later assigns no ID.
- R8: chain_out_o goes high one cycle after id_valid_o is set, so the next device samples it at bit position c+2. It goes low at the next frame edge and stays 0 while id_mode_i is low.
- R9: The lowest 8 bits of every packet have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_clk_i | input | 1 | Frame clock; a rising edge starts a frame |
| sdata_i | input | 1 | Serial packet data, MSB first |
| chain_in_i | input | 1 | Daisy-chain token from the previous device |
| long_frame_i | input | 1 | 0: 256-bit frame with 6 slots, 1: 384-bit frame with 8 slots |
| id_mode_i | input | 1 | Enables the chain ID assignment |
| start_slot_i | input | 3 | First audio slot taken by this device |
| slot_count_i | input | 4 | Number of consecutive audio slots taken |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_data_o | output | 24 | Upper 24 bits of the command packet |
| aud_valid_o | output | 1 | One-cycle audio strobe |
| aud_data_o | output | 24 | 24-bit audio sample |
| aud_slot_o | output | 3 | Slot number of aud_data_o |
| frame_err_o | output | 1 | Previous frame had the wrong bit count |
| dev_id_o | output | 5 | Assigned device ID |
| id_valid_o | output | 1 | dev_id_o holds an assigned ID |
| chain_out_o | output | 1 | Token passed to the next device |

## Verification
The assertions assume that start_slot_i, slot_count_i and long_frame_i change only between frames. They also assume that all inputs are steady around the rising bit-clock edge. The bench drives every input on the falling edge and changes the configuration only before the first bit of a frame. This keeps the window check, which compares against the previous cycle's configuration, valid. Random frames mix both lengths, random slot windows, and random low bytes. Directed frames cover early and late frame edges, empty and edge-of-range windows, and chain tokens at positions 0, 58 and 60.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
   function automatic logic slot_in_window(input int slot, input int first, input int count,
                                           input int limit);
      return (slot >= first) && (slot < first + count) && (slot < limit);
   endfunction
endpackage

// File: rtl/tdm_frame_tracker.sv
module tdm_frame_tracker #(
   parameter int SHORT_FRAME = 256,
   parameter int LONG_FRAME  = 384,
   parameter int CNT_W       = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_clk_i,
   input  logic             long_i,
   output logic [CNT_W-1:0] pos_o,
   output logic             in_frame_o,
   output logic             fedge_o,
   output logic             long_o,
   output logic             synced_o,
   output logic             err_o
);
   localparam logic [CNT_W-1:0] SHORT_LEN = CNT_W'(SHORT_FRAME);
   localparam logic [CNT_W-1:0] LONG_LEN  = CNT_W'(LONG_FRAME);

   if (LONG_FRAME < SHORT_FRAME) begin : g_bad_len
      $error("long frame shorter than short frame");
   end
   if ((1 << CNT_W) <= LONG_FRAME) begin : g_bad_cnt
      $error("bit counter too narrow");
   end

   logic             fclk_q, synced_q, long_q, err_q;
   logic [CNT_W-1:0] cnt_q, cur_len, prev_len, pos;

   assign fedge_o  = frame_clk_i & ~fclk_q;
   assign long_o   = fedge_o ? long_i : long_q;
   assign cur_len  = long_o ? LONG_LEN : SHORT_LEN;
   assign prev_len = long_q ? LONG_LEN : SHORT_LEN;

   always_comb begin
      if (fedge_o)                pos = '0;
      else if (cnt_q >= cur_len)  pos = cur_len;
      else                        pos = cnt_q + 1'b1;
   end

   assign pos_o      = pos;
   assign synced_o   = synced_q | fedge_o;
   assign in_frame_o = synced_o && (pos < cur_len);
   assign err_o      = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fclk_q   <= 1'b0;
         synced_q <= 1'b0;
         long_q   <= 1'b0;
         err_q    <= 1'b0;
         cnt_q    <= '0;
      end else begin
         fclk_q <= frame_clk_i;
         cnt_q  <= pos;
         if (fedge_o) begin
            synced_q <= 1'b1;
            long_q   <= long_i;
            err_q    <= synced_q && (cnt_q != prev_len - 1'b1);
         end
      end
   end

   assert_err_at_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> $past(fedge_o));
   assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LONG_LEN);
endmodule

// File: rtl/tdm_packet_shifter.sv
module tdm_packet_shifter #(
   parameter int PKT_BITS  = 32,
   parameter int DATA_BITS = 24,
   parameter int CNT_W     = 9,
   parameter int IDX_W     = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 sdata_i,
   input  logic [CNT_W-1:0]     pos_i,
   input  logic                 in_frame_i,
   output logic                 done_o,
   output logic [IDX_W-1:0]     idx_o,
   output logic [DATA_BITS-1:0] word_o
);
   localparam int PKT_LOG = $clog2(PKT_BITS);

   if ((1 << PKT_LOG) != PKT_BITS) begin : g_bad_pkt
      $error("packet length must be a power of two");
   end
   if (DATA_BITS > PKT_BITS) begin : g_bad_data
      $error("data wider than packet");
   end
   if (IDX_W != CNT_W - PKT_LOG) begin : g_bad_idx
      $error("index width mismatch");
   end

   logic [PKT_BITS-2:0] sh_q;
   logic [PKT_BITS-1:0] full;

   assign full   = {sh_q, sdata_i};
   assign done_o = in_frame_i && (&pos_i[PKT_LOG-1:0]);
   assign idx_o  = pos_i[CNT_W-1:PKT_LOG];
   assign word_o = full[PKT_BITS-1 -: DATA_BITS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= full[PKT_BITS-2:0];
   end
endmodule

// File: rtl/tdm_slot_router.sv
module tdm_slot_router
   import tdm_rx_pkg::*;
#(
   parameter int DATA_BITS   = 24,
   parameter int SHORT_SLOTS = 6,
   parameter int LONG_SLOTS  = 8,
   parameter int IDX_W       = 4,
   parameter int SLOT_W      = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 done_i,
   input  logic [IDX_W-1:0]     idx_i,
   input  logic [DATA_BITS-1:0] word_i,
   input  logic                 long_i,
   input  logic [SLOT_W-1:0]    start_i,
   input  logic [SLOT_W:0]      count_i,
   output logic                 cmd_valid_o,
   output logic [DATA_BITS-1:0] cmd_data_o,
   output logic                 aud_valid_o,
   output logic [DATA_BITS-1:0] aud_data_o,
   output logic [SLOT_W-1:0]    aud_slot_o
);
   if (SHORT_SLOTS > LONG_SLOTS) begin : g_bad_slots
      $error("short slot count exceeds long slot count");
   end
   if ((1 << SLOT_W) < LONG_SLOTS) begin : g_bad_slot_w
      $error("slot width too narrow");
   end

   logic [LONG_SLOTS-1:0] hit;
   int                    limit;

   assign limit = long_i ? LONG_SLOTS : SHORT_SLOTS;

   for (genvar g = 0; g < LONG_SLOTS; g++) begin : g_slot
      assign hit[g] = slot_in_window(g, int'(start_i), int'(count_i), limit);
   end

   logic             is_audio, take;
   logic [IDX_W-1:0] slot_raw;

   assign slot_raw = idx_i - 1'b1;
   assign is_audio = (idx_i != '0) && (int'(idx_i) <= LONG_SLOTS);
   assign take     = done_i && is_audio && hit[slot_raw[SLOT_W-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_valid_o <= 1'b0;
         cmd_data_o  <= '0;
         aud_valid_o <= 1'b0;
         aud_data_o  <= '0;
         aud_slot_o  <= '0;
      end else begin
         cmd_valid_o <= done_i && (idx_i == '0);
         aud_valid_o <= take;
         if (done_i && (idx_i == '0)) cmd_data_o <= word_i;
         if (take) begin
            aud_data_o <= word_i;
            aud_slot_o <= slot_raw[SLOT_W-1:0];
         end
      end
   end

   assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid_o && aud_valid_o));
   assert_aud_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      aud_valid_o |=> !aud_valid_o);
   assert_slot_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
      aud_valid_o |-> (int'(aud_slot_o) >= int'($past(start_i))) &&
                      (int'(aud_slot_o) < int'($past(start_i)) + int'($past(count_i))));
endmodule

// File: rtl/tdm_chain_id.sv
module tdm_chain_id #(
   parameter int ID_MAX = 30,
   parameter int ID_W   = 5,
   parameter int CNT_W  = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fedge_i,
   input  logic             synced_i,
   input  logic [CNT_W-1:0] pos_i,
   input  logic             id_mode_i,
   input  logic             chain_in_i,
   output logic [ID_W-1:0]  dev_id_o,
   output logic             id_valid_o,
   output logic             chain_out_o
);
   localparam logic [CNT_W-1:0] ID_SPAN = CNT_W'(2 * ID_MAX);

   if (ID_MAX >= (1 << ID_W)) begin : g_bad_id
      $error("ID width too narrow");
   end
   if ((1 << CNT_W) <= 2 * ID_MAX) begin : g_bad_span
      $error("ID window exceeds counter");
   end

   logic tok_q, tok_eff, cap;

   assign tok_eff = fedge_i ? 1'b0 : tok_q;
   assign cap     = id_mode_i && synced_i && !tok_eff && chain_in_i && (pos_i < ID_SPAN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tok_q       <= 1'b0;
         dev_id_o    <= '0;
         id_valid_o  <= 1'b0;
         chain_out_o <= 1'b0;
      end else begin
         chain_out_o <= id_mode_i && tok_q && !fedge_i;
         if (fedge_i && id_mode_i) begin
            tok_q      <= 1'b0;
            id_valid_o <= 1'b0;
         end
         if (cap) begin
            tok_q      <= 1'b1;
            id_valid_o <= 1'b1;
            dev_id_o   <= ID_W'(pos_i >> 1) + 1'b1;
         end
      end
   end

   assert_id_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
      id_valid_o |-> (dev_id_o >= 1) && (int'(dev_id_o) <= ID_MAX));
   assert_chain_needs_id_R8: assert property (@(posedge clk) disable iff (!rst_n)
      chain_out_o |-> id_valid_o);
   assert_chain_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(id_mode_i) |-> !chain_out_o);
endmodule

// File: rtl/tdm_cmd_audio_rx.sv
module tdm_cmd_audio_rx #(
   parameter int PKT_BITS    = 32,
   parameter int DATA_BITS   = 24,
   parameter int SHORT_FRAME = 256,
   parameter int LONG_FRAME  = 384,
   parameter int SHORT_SLOTS = 6,
   parameter int LONG_SLOTS  = 8,
   parameter int ID_MAX      = 30,
   parameter int ID_W        = 5,
   parameter int SLOT_W      = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 frame_clk_i,
   input  logic                 sdata_i,
   input  logic                 chain_in_i,
   input  logic                 long_frame_i,
   input  logic                 id_mode_i,
   input  logic [SLOT_W-1:0]    start_slot_i,
   input  logic [SLOT_W:0]      slot_count_i,
   output logic                 cmd_valid_o,
   output logic [DATA_BITS-1:0] cmd_data_o,
   output logic                 aud_valid_o,
   output logic [DATA_BITS-1:0] aud_data_o,
   output logic [SLOT_W-1:0]    aud_slot_o,
   output logic                 frame_err_o,
   output logic [ID_W-1:0]      dev_id_o,
   output logic                 id_valid_o,
   output logic                 chain_out_o
);
   localparam int CNT_W = $clog2(LONG_FRAME + 1);
   localparam int IDX_W = CNT_W - $clog2(PKT_BITS);

   logic [CNT_W-1:0]     pos;
   logic                 in_frame, fedge, cur_long, synced, done;
   logic [IDX_W-1:0]     idx;
   logic [DATA_BITS-1:0] word;

   tdm_frame_tracker #(.SHORT_FRAME(SHORT_FRAME), .LONG_FRAME(LONG_FRAME), .CNT_W(CNT_W))
   u_track (
      .clk(clk), .rst_n(rst_n), .frame_clk_i(frame_clk_i), .long_i(long_frame_i),
      .pos_o(pos), .in_frame_o(in_frame), .fedge_o(fedge), .long_o(cur_long),
      .synced_o(synced), .err_o(frame_err_o)
   );

   tdm_packet_shifter #(.PKT_BITS(PKT_BITS), .DATA_BITS(DATA_BITS), .CNT_W(CNT_W),
                        .IDX_W(IDX_W))
   u_shift (
      .clk(clk), .rst_n(rst_n), .sdata_i(sdata_i), .pos_i(pos), .in_frame_i(in_frame),
      .done_o(done), .idx_o(idx), .word_o(word)
   );

   tdm_slot_router #(.DATA_BITS(DATA_BITS), .SHORT_SLOTS(SHORT_SLOTS),
                     .LONG_SLOTS(LONG_SLOTS), .IDX_W(IDX_W), .SLOT_W(SLOT_W))
   u_route (
      .clk(clk), .rst_n(rst_n), .done_i(done), .idx_i(idx), .word_i(word),
      .long_i(cur_long), .start_i(start_slot_i), .count_i(slot_count_i),
      .cmd_valid_o(cmd_valid_o), .cmd_data_o(cmd_data_o), .aud_valid_o(aud_valid_o),
      .aud_data_o(aud_data_o), .aud_slot_o(aud_slot_o)
   );

   tdm_chain_id #(.ID_MAX(ID_MAX), .ID_W(ID_W), .CNT_W(CNT_W))
   u_chain (
      .clk(clk), .rst_n(rst_n), .fedge_i(fedge), .synced_i(synced), .pos_i(pos),
      .id_mode_i(id_mode_i), .chain_in_i(chain_in_i), .dev_id_o(dev_id_o),
      .id_valid_o(id_valid_o), .chain_out_o(chain_out_o)
   );
endmodule

// File: tb/tdm_cmd_audio_rx_tb.sv
module tdm_cmd_audio_rx_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fclk = 1'b0, sdata = 1'b0, cin = 1'b0, lng = 1'b0, idm = 1'b0;
   logic [2:0]  st = '0;
   logic [3:0]  cnt = '0;
   logic        cmd_v, aud_v, ferr, idv, cout;
   logic [23:0] cmd_d, aud_d;
   logic [2:0]  aud_s;
   logic [4:0]  dev_id;

   int checks = 0, fails = 0;
   bit done = 0;
   logic [31:0] pk [12];

   always #2 clk = ~clk;

   tdm_cmd_audio_rx u_dut (
      .clk(clk), .rst_n(rst_n), .frame_clk_i(fclk), .sdata_i(sdata), .chain_in_i(cin),
      .long_frame_i(lng), .id_mode_i(idm), .start_slot_i(st), .slot_count_i(cnt),
      .cmd_valid_o(cmd_v), .cmd_data_o(cmd_d), .aud_valid_o(aud_v), .aud_data_o(aud_d),
      .aud_slot_o(aud_s), .frame_err_o(ferr), .dev_id_o(dev_id), .id_valid_o(idv),
      .chain_out_o(cout)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic bit exp_hit(int slot, int first, int count, bit long_f);
      return slot >= first && slot < first + count && slot < (long_f ? 8 : 6);
   endfunction

   task automatic step(input logic f, input logic d, input logic c);
      @(negedge clk);
      fclk = f; sdata = d; cin = c;
      @(posedge clk);
      #1;
   endtask

   task automatic fill_random();
      for (int k = 0; k < 12; k++) pk[k] = $urandom;
   endtask

   // nbits: bits actually sent; ci_at: first chain-in position or -1; err_exp: flag after bit 0
   task automatic send_frame(input int nbits, input int ci_at, input bit err_exp);
      int  len  = lng ? 384 : 256;
      bit  quiet = 1;
      for (int i = 0; i < nbits; i++) begin
         step(i < 16, pk[i / 32][31 - (i % 32)], (ci_at >= 0) && (i >= ci_at));
         if (i == 0) chk(ferr == err_exp, "R6", "frame error at edge", ferr, err_exp);
         if (i == 0 && idm && ci_at != 0) chk(idv == 0, "R7", "id cleared at edge", idv, 0);
         if (idm && ci_at >= 0 && ci_at < 60 && i == ci_at) begin
            chk(idv == 1, "R7", "id valid", idv, 1);
            chk(dev_id == ci_at / 2 + 1, "R7", "device id", dev_id, ci_at / 2 + 1);
            chk(cout == 0, "R8", "chain out still low", cout, 0);
         end
         if (idm && ci_at >= 0 && ci_at < 60 && i == ci_at + 1)
            chk(cout == 1, "R8", "chain out raised", cout, 1);
         if ((i % 32) == 31 && i < len) begin
            int p = i / 32;
            if (p == 0) begin
               chk(cmd_v == 1, "R3", "command strobe", cmd_v, 1);
               chk(cmd_d == pk[0][31:8], "R9", "command data", cmd_d, pk[0][31:8]);
               chk(aud_v == 0, "R3", "no audio on command", aud_v, 0);
            end else if (exp_hit(p - 1, st, cnt, lng)) begin
               chk(aud_v == 1, "R4", "audio strobe", aud_v, 1);
               chk(aud_d == pk[p][31:8], "R9", "audio data", aud_d, pk[p][31:8]);
               chk(aud_s == 3'(p - 1), "R4", "audio slot", aud_s, p - 1);
            end else begin
               chk(aud_v == 0 && cmd_v == 0, "R5", "slot not taken", aud_v, 0);
            end
         end else if (cmd_v || aud_v) quiet = 0;
      end
      chk(quiet, "R4", "no stray strobes in frame", !quiet, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20061));
      repeat (3) @(posedge clk);
      #1;
      chk(cmd_v == 0 && aud_v == 0, "R1", "strobes after reset", {cmd_v, aud_v}, 0);
      chk(ferr == 0 && idv == 0 && cout == 0, "R1", "flags after reset",
          {ferr, idv, cout}, 0);
      rst_n = 1'b1;

      // R2: data toggling before any frame edge yields nothing
      begin
         bit seen = 0;
         for (int i = 0; i < 70; i++) begin
            step(1'b0, 1'b1, 1'b0);
            if (cmd_v || aud_v) seen = 1;
         end
         chk(!seen, "R2", "no strobes before first frame edge", seen, 0);
      end

      // first frame: short, all slots, no error on first edge
      lng = 0; st = 0; cnt = 6; fill_random();
      send_frame(256, -1, 0);

      // random frames, R5 and R4 with varied windows
      for (int f = 0; f < 24; f++) begin
         bit prev_long = lng;
         lng = 1'($urandom);
         st  = 3'($urandom);
         cnt = 4'($urandom_range(0, 8));
         fill_random();
         send_frame(lng ? 384 : 256, -1, 0);
         if (f == 0) chk(prev_long == 0, "R5", "sequence start", prev_long, 0);
      end

      // directed windows
      lng = 0; st = 5; cnt = 3; fill_random(); send_frame(256, -1, 0);
      lng = 1; st = 7; cnt = 1; fill_random(); send_frame(384, -1, 0);
      lng = 1; st = 0; cnt = 0; fill_random(); send_frame(384, -1, 0);
      lng = 0; st = 0; cnt = 8; fill_random(); send_frame(256, -1, 0);

      // R6: early edge, then late edge, then recovery
      lng = 0; st = 0; cnt = 6; fill_random(); send_frame(200, -1, 0);
      fill_random(); send_frame(300, -1, 1);
      fill_random(); send_frame(256, -1, 1);
      fill_random(); send_frame(256, -1, 0);

      // R7 / R8: chain ID assignment
      idm = 1; lng = 0; st = 0; cnt = 2;
      fill_random(); send_frame(256, 0, 0);
      fill_random(); send_frame(256, 58, 0);
      fill_random(); send_frame(256, 13, 0);
      fill_random(); send_frame(256, 60, 0);
      chk(idv == 0, "R7", "late token assigns nothing", idv, 0);
      chk(cout == 0, "R8", "no chain out without id", cout, 0);
      fill_random(); send_frame(256, 4, 0);
      idm = 0;
      fill_random(); send_frame(256, 0, 0);
      chk(cout == 0, "R8", "chain out low when id mode off", cout, 0);
      chk(idv == 1 && dev_id == 3, "R7", "id kept when id mode off", dev_id, 3);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule